// File: doc/BRIEF.md
# Pixel Lookup Table with Saturation Override

This block maps an 8-bit pixel value through a 256-entry table of bytes and presents the result, zero-extended, on a 32-bit output one clock later. Two pairs of overflow flags come from upstream arithmetic stages. Each pair has one flag from each of two sources, and the two flags of a pair are ORed. When the positive pair is raised, the output is replaced by a programmable 32-bit upper constant. When only the negative pair is raised, the output is replaced by a programmable 32-bit lower constant.

A host programs the table and both constants through a byte-wide port. The table occupies host addresses 0x100 to 0x1FF. Byte address 0x100 + i is the entry that pixel value i selects, so the table can also be handled as 32-bit little-endian words: word n occupies addresses 0x100 + 4n (least significant byte) to 0x100 + 4n + 3. The upper constant sits at 0x000 to 0x003 and the lower constant at 0x004 to 0x007, both least significant byte first. While the run-lock input is high, host writes are dropped and host reads return zero.

Top module: `lut_sat_unit`

## Requirements
- R1: During and directly after a synchronous reset, `lut_out` is 0 and `host_rvalid` is 0. Both saturation constants reset to 0.
- R2: With no overflow flag raised, `lut_out` equals {24'b0, table[pix_idx]} one clock edge after `pix_idx` is presented.
- R3: If `ovf_pos_a` or `ovf_pos_b` is high, `lut_out` equals the upper constant one clock edge later.
- R4: If `ovf_neg_a` or `ovf_neg_b` is high and no positive flag is high, `lut_out` equals the lower constant one clock edge later.
- R5: If a positive flag and a negative flag are both high, the upper constant is output.
- R6: Host byte address 0x100 + i holds the table entry that pixel value i selects. Word n of the 32-bit view therefore has bits 8k+7:8k at address 0x100 + 4n + k.
- R7: Upper-constant byte k (bits 8k+7:8k) is at address 0x000 + k, and lower-constant byte k is at address 0x004 + k, for k = 0..3.
- R8: A read request (`host_sel` high, `host_we` low) raises `host_rvalid` with the addressed byte on `host_rdata` one clock edge later. `host_rvalid` is low after any cycle without a read request.
- R9: A host write made while `run_lock` is high changes neither the table nor the constants.
- R10: A host read made while `run_lock` is high returns 0 with `host_rvalid` high.
- R11: A read of an address below 0x100 other than 0x000 to 0x007 returns 0, and a write to such an address has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_lock | input | 1 | High: host access blocked |
| pix_idx | input | 8 | Pixel value indexing the table |
| ovf_pos_a | input | 1 | Positive overflow, source A |
| ovf_pos_b | input | 1 | Positive overflow, source B |
| ovf_neg_a | input | 1 | Negative overflow, source A |
| ovf_neg_b | input | 1 | Negative overflow, source B |
| lut_out | output | 32 | Mapped or saturated value |
| host_sel | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 9 | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | 8 | Read data byte |

## Verification
`lut_out` is due one rising edge after the pixel value and flags are presented. `host_rvalid` and `host_rdata` are due one rising edge after a read request. A write is visible to a read or lookup issued in the following cycle. The bench's reference model computes each expectation at the same rising edge that the design uses to register its result. It compares the two at the next falling edge, so every comparison looks at exactly the cycle in which the result is due.

// File: rtl/lut_sat_pkg.sv
package lut_sat_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_HI   = 2'd1,
    RGN_LO   = 2'd2,
    RGN_TAB  = 2'd3
  } region_e;
endpackage

// File: rtl/lut_sat_ram.sv
module lut_sat_ram #(
  parameter int IDX_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  dp_idx,
  output logic [BYTE_W-1:0] dp_q,
  input  logic              hs_we,
  input  logic [IDX_W-1:0]  hs_idx,
  input  logic [BYTE_W-1:0] hs_wdata,
  output logic [BYTE_W-1:0] hs_q
);
  localparam int DEPTH = 1 << IDX_W;

  logic [BYTE_W-1:0] mem [DEPTH];

  // single clock, read-first on both ports
  always_ff @(posedge clk) begin
    if (hs_we) mem[hs_idx] <= hs_wdata;
    dp_q <= mem[dp_idx];
    hs_q <= mem[hs_idx];
  end
endmodule

// File: rtl/lut_sat_regs.sv
module lut_sat_regs
  import lut_sat_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int SAT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output region_e           region,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [SAT_W-1:0]  sat_hi,
  output logic [SAT_W-1:0]  sat_lo
);
  localparam int SAT_BYTES = SAT_W / BYTE_W;
  localparam int SAT_AW    = $clog2(SAT_BYTES);

  logic [SAT_AW-1:0] byte_sel;
  assign byte_sel = addr[SAT_AW-1:0];

  always_comb begin
    if (addr[ADDR_W-1])
      region = RGN_TAB;
    else if (addr[ADDR_W-2:SAT_AW+1] != '0)
      region = RGN_NONE;
    else if (addr[SAT_AW])
      region = RGN_LO;
    else
      region = RGN_HI;
  end

  generate
    for (genvar k = 0; k < SAT_BYTES; k++) begin : g_byte
      always_ff @(posedge clk) begin
        if (rst) begin
          sat_hi[k*BYTE_W +: BYTE_W] <= '0;
          sat_lo[k*BYTE_W +: BYTE_W] <= '0;
        end else if (wr_en && byte_sel == SAT_AW'(k)) begin
          if (region == RGN_HI) sat_hi[k*BYTE_W +: BYTE_W] <= wdata;
          if (region == RGN_LO) sat_lo[k*BYTE_W +: BYTE_W] <= wdata;
        end
      end
    end
  endgenerate

  always_comb begin
    case (region)
      RGN_HI:  rd_byte = sat_hi[byte_sel*BYTE_W +: BYTE_W];
      RGN_LO:  rd_byte = sat_lo[byte_sel*BYTE_W +: BYTE_W];
      default: rd_byte = '0;
    endcase
  end
endmodule

// File: rtl/lut_sat_ovr.sv
module lut_sat_ovr
  import lut_sat_pkg::*;
#(
  parameter int SAT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pos_any,
  input  logic              neg_any,
  input  logic [SAT_W-1:0]  sat_hi,
  input  logic [SAT_W-1:0]  sat_lo,
  input  logic [BYTE_W-1:0] tab_q,
  output logic [SAT_W-1:0]  dout
);
  logic             ovr_q;
  logic [SAT_W-1:0] sat_q;
  logic             live_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q  <= 1'b0;
      sat_q  <= '0;
      live_q <= 1'b0;
    end else begin
      ovr_q  <= pos_any | neg_any;
      sat_q  <= pos_any ? sat_hi : sat_lo;  // upper wins on conflict
      live_q <= 1'b1;
    end
  end

  always_comb begin
    if (!live_q)
      dout = '0;
    else if (ovr_q)
      dout = sat_q;
    else
      dout = {{(SAT_W-BYTE_W){1'b0}}, tab_q};
  end
endmodule

// File: rtl/lut_sat_unit.sv
module lut_sat_unit
  import lut_sat_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int SAT_W  = 32,
  parameter int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_lock,
  input  logic [IDX_W-1:0]  pix_idx,
  input  logic              ovf_pos_a,
  input  logic              ovf_pos_b,
  input  logic              ovf_neg_a,
  input  logic              ovf_neg_b,
  output logic [SAT_W-1:0]  lut_out,
  input  logic              host_sel,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic              host_rvalid,
  output logic [7:0]        host_rdata
);
  logic              access;
  logic              wr_any;
  logic              rd_req;
  region_e           region;
  logic [BYTE_W-1:0] reg_byte;
  logic [SAT_W-1:0]  sat_hi;
  logic [SAT_W-1:0]  sat_lo;
  logic [BYTE_W-1:0] dp_q;
  logic [BYTE_W-1:0] hs_q;
  logic              rd_tab_q;
  logic [BYTE_W-1:0] rd_reg_q;

  assign access = host_sel & ~run_lock;
  assign wr_any = access & host_we;
  assign rd_req = host_sel & ~host_we;

  lut_sat_regs #(.ADDR_W(ADDR_W), .SAT_W(SAT_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_any),
    .addr    (host_addr),
    .wdata   (host_wdata),
    .region  (region),
    .rd_byte (reg_byte),
    .sat_hi  (sat_hi),
    .sat_lo  (sat_lo)
  );

  lut_sat_ram #(.IDX_W(IDX_W), .BYTE_W(BYTE_W)) u_ram (
    .clk      (clk),
    .dp_idx   (pix_idx),
    .dp_q     (dp_q),
    .hs_we    (wr_any && region == RGN_TAB),
    .hs_idx   (host_addr[IDX_W-1:0]),
    .hs_wdata (host_wdata),
    .hs_q     (hs_q)
  );

  lut_sat_ovr #(.SAT_W(SAT_W)) u_ovr (
    .clk     (clk),
    .rst     (rst),
    .pos_any (ovf_pos_a | ovf_pos_b),
    .neg_any (ovf_neg_a | ovf_neg_b),
    .sat_hi  (sat_hi),
    .sat_lo  (sat_lo),
    .tab_q   (dp_q),
    .dout    (lut_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rvalid <= 1'b0;
      rd_tab_q    <= 1'b0;
      rd_reg_q    <= '0;
    end else begin
      host_rvalid <= rd_req;
      rd_tab_q    <= rd_req && access && region == RGN_TAB;
      rd_reg_q    <= (rd_req && access) ? reg_byte : '0;
    end
  end

  assign host_rdata = rd_tab_q ? hs_q : rd_reg_q;
endmodule

// File: rtl/lut_sat_unit_chk.sv
module lut_sat_unit_chk #(
  parameter int SAT_W  = 32,
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              run_lock,
  input logic              ovf_pos_a,
  input logic              ovf_pos_b,
  input logic              ovf_neg_a,
  input logic              ovf_neg_b,
  input logic [SAT_W-1:0]  lut_out,
  input logic              host_sel,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_rvalid,
  input logic [7:0]        host_rdata,
  input logic [SAT_W-1:0]  sat_hi,
  input logic [SAT_W-1:0]  sat_lo
);
  a_r1_reset_clear: assert property (@(posedge clk)
    $fell(rst) |-> (lut_out == '0 && !host_rvalid));

  a_r3_upper_sel: assert property (@(posedge clk) disable iff (rst)
    (ovf_pos_a || ovf_pos_b) |=> lut_out == $past(sat_hi));

  a_r4_lower_sel: assert property (@(posedge clk) disable iff (rst)
    (!ovf_pos_a && !ovf_pos_b && (ovf_neg_a || ovf_neg_b)) |=> lut_out == $past(sat_lo));

  a_r8_rvalid_on: assert property (@(posedge clk) disable iff (rst)
    (host_sel && !host_we) |=> host_rvalid);

  a_r8_rvalid_off: assert property (@(posedge clk) disable iff (rst)
    !(host_sel && !host_we) |=> !host_rvalid);

  a_r9_locked_hold: assert property (@(posedge clk) disable iff (rst)
    run_lock |=> ($stable(sat_hi) && $stable(sat_lo)));

  a_r10_locked_zero: assert property (@(posedge clk) disable iff (rst)
    (host_sel && !host_we && run_lock) |=> host_rdata == 8'd0);

  a_r11_hole_zero: assert property (@(posedge clk) disable iff (rst)
    (host_sel && !host_we && !host_addr[ADDR_W-1] && host_addr[ADDR_W-2:0] > 7)
      |=> host_rdata == 8'd0);
endmodule

bind lut_sat_unit lut_sat_unit_chk #(.SAT_W(SAT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .run_lock    (run_lock),
  .ovf_pos_a   (ovf_pos_a),
  .ovf_pos_b   (ovf_pos_b),
  .ovf_neg_a   (ovf_neg_a),
  .ovf_neg_b   (ovf_neg_b),
  .lut_out     (lut_out),
  .host_sel    (host_sel),
  .host_we     (host_we),
  .host_addr   (host_addr),
  .host_rvalid (host_rvalid),
  .host_rdata  (host_rdata),
  .sat_hi      (sat_hi),
  .sat_lo      (sat_lo)
);

// File: tb/lut_sat_unit_tb.sv
`timescale 1ns/1ps
module lut_sat_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_lock = 1'b0;
  logic [7:0]  pix_idx = '0;
  logic        ovf_pos_a = 0, ovf_pos_b = 0, ovf_neg_a = 0, ovf_neg_b = 0;
  logic [31:0] lut_out;
  logic        host_sel = 0, host_we = 0;
  logic [8:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_rvalid;
  logic [7:0]  host_rdata;

  always #4 clk = ~clk;

  lut_sat_unit u_dut (.*);

  // reference state
  logic [7:0]  tab [256];
  logic [31:0] m_hi, m_lo;
  logic [31:0] e_out;
  logic        e_rv;
  logic [7:0]  e_rd;
  string       e_dtag, e_rtag, note;
  bit          dp_en = 0;
  int          checks = 0, errors = 0;

  function automatic logic [7:0] ref_read(input logic [8:0] a);
    if (a[8]) return tab[a[7:0]];
    if (a < 9'd4) return m_hi[a[1:0]*8 +: 8];
    if (a < 9'd8) return m_lo[a[1:0]*8 +: 8];
    return 8'd0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      e_out <= '0; e_rv <= 1'b0; e_rd <= '0; m_hi <= '0; m_lo <= '0;
      e_dtag <= "R1"; e_rtag <= "R1";
    end else begin
      if (ovf_pos_a | ovf_pos_b) begin
        e_out <= m_hi;
        e_dtag <= (ovf_neg_a | ovf_neg_b) ? "R5" : "R3";
      end else if (ovf_neg_a | ovf_neg_b) begin
        e_out <= m_lo; e_dtag <= "R4";
      end else begin
        e_out <= {24'd0, tab[pix_idx]};
        e_dtag <= (note != "") ? note : "R2";
      end
      e_rv <= host_sel && !host_we;
      if (host_sel && !host_we) begin
        e_rd <= run_lock ? 8'd0 : ref_read(host_addr);
        if (note != "") e_rtag <= note;
        else if (run_lock) e_rtag <= "R10";
        else if (host_addr[8]) e_rtag <= "R6";
        else if (host_addr < 9'd8) e_rtag <= "R7";
        else e_rtag <= "R11";
      end
      if (host_sel && host_we && !run_lock) begin
        if (host_addr[8]) tab[host_addr[7:0]] <= host_wdata;
        else if (host_addr < 9'd4) m_hi[host_addr[1:0]*8 +: 8] <= host_wdata;
        else if (host_addr < 9'd8) m_lo[host_addr[1:0]*8 +: 8] <= host_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (host_rvalid !== e_rv) begin
        errors++;
        $display("FAIL R8 host_rvalid actual %0b expected %0b", host_rvalid, e_rv);
      end
      if (e_rv) begin
        checks++;
        if (host_rdata !== e_rd) begin
          errors++;
          $display("FAIL %s host_rdata actual %02h expected %02h", e_rtag, host_rdata, e_rd);
        end
      end
      if (dp_en) begin
        checks++;
        if (lut_out !== e_out) begin
          errors++;
          $display("FAIL %s lut_out actual %08h expected %08h", e_dtag, lut_out, e_out);
        end
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    host_sel = 0; host_we = 0;
    {ovf_pos_a, ovf_pos_b, ovf_neg_a, ovf_neg_b} = 4'b0;
  endtask

  task automatic hwr(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    host_sel = 1; host_we = 1; host_addr = a; host_wdata = d;
  endtask

  task automatic hrd(input logic [8:0] a);
    @(negedge clk);
    host_sel = 1; host_we = 0; host_addr = a;
  endtask

  task automatic px(input logic [7:0] i, input logic [3:0] f);
    @(negedge clk);
    host_sel = 0; host_we = 0; pix_idx = i;
    {ovf_pos_a, ovf_pos_b, ovf_neg_a, ovf_neg_b} = f;
  endtask

  initial begin
    note = "";
    // R1: reset values
    repeat (3) @(negedge clk);
    checks++;
    if (lut_out !== 32'd0 || host_rvalid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs actual %08h/%0b expected 0/0", lut_out, host_rvalid);
    end
    @(negedge clk); rst = 0;
    checks++;
    if (lut_out !== 32'd0 || host_rvalid !== 1'b0) begin
      errors++;
      $display("FAIL R1 after reset actual %08h/%0b expected 0/0", lut_out, host_rvalid);
    end
    // R1/R7: constants read zero after reset
    note = "R1";
    for (int a = 0; a < 8; a++) hrd(9'(a));
    idle(); note = "";
    // fill table (R6)
    for (int i = 0; i < 256; i++) hwr(9'h100 + 9'(i), 8'((i * 37 + 11) & 255));
    // R7 constants
    hwr(9'h000, 8'hD4); hwr(9'h001, 8'hC3); hwr(9'h002, 8'hB2); hwr(9'h003, 8'hA1);
    hwr(9'h004, 8'h3C); hwr(9'h005, 8'h2D); hwr(9'h006, 8'h1E); hwr(9'h007, 8'h0F);
    // R11 writes to holes
    hwr(9'h008, 8'h55); hwr(9'h0FF, 8'h66);
    idle(); dp_en = 1;
    for (int a = 0; a < 8; a++) hrd(9'(a));
    hrd(9'h008); hrd(9'h0FF); hrd(9'h0A5);
    hrd(9'h100); hrd(9'h17F); hrd(9'h1FF);
    idle();
    // R6 word view: word 5 = 0x44332211
    hwr(9'h114, 8'h11); hwr(9'h115, 8'h22); hwr(9'h116, 8'h33); hwr(9'h117, 8'h44);
    note = "R6";
    for (int k = 20; k < 24; k++) px(8'(k), 4'b0000);
    idle(); note = "";
    // locked run: sweep with flag patterns (R2..R5)
    @(negedge clk); run_lock = 1;
    for (int i = 0; i < 256; i++) begin
      logic [3:0] f;
      case (i % 8)
        1: f = 4'b1000; 2: f = 4'b0100; 3: f = 4'b0010; 4: f = 4'b0001;
        5: f = 4'b1010; 6: f = 4'b0101; 7: f = 4'b1111; default: f = 4'b0000;
      endcase
      px(8'(255 - i), f);
    end
    idle();
    // R9/R10 locked writes and reads
    hwr(9'h105, 8'hEE); hwr(9'h000, 8'hEE); hwr(9'h006, 8'hEE);
    hrd(9'h105); hrd(9'h000); hrd(9'h006);
    px(8'd5, 4'b1000); px(8'd5, 4'b0001); px(8'd5, 4'b0000);
    idle();
    @(negedge clk); run_lock = 0;
    note = "R9";
    hrd(9'h105); hrd(9'h000); hrd(9'h006);
    idle(); note = "";
    // unlocked override while host idle (R3, R4, R5)
    px(8'd9, 4'b0100); px(8'd9, 4'b0010); px(8'd9, 4'b1001); px(8'd9, 4'b0000);
    idle(); idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog (all requirements) actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule